// File: doc/BRIEF.md
# Windowed Address Decoder and Translator

This block holds up to six address windows and decides, in the same cycle, which of them an incoming 32-bit bus address falls into. For the matching window it reports a hit, the window number, the window's space type and its prefetch and read-line flags. When that window has translation switched on, it also replaces the masked upper address bits with the window's translation value.

Window 0 is fixed. It is a single 4 KB configuration page whose base comes from a parameter. It does no translation, it is always memory space and its flags are clear. Windows 1 to `NUM_WIN-1` are programmed through a small register write port and read back through a separate combinational read port. Windows at or above `NUM_WIN` are absent. They read as zero and never match.

All window fields cover address bits 31:12, so windows are aligned to 4 KB. The lookup is purely combinational. Register writes take effect at the next rising clock edge.

Top module: `addr_win_decoder`

## Requirements
- R1: A window hits when its mask is nonzero and (addr[31:12] & mask) equals (base[31:12] & mask). A window whose mask is zero never hits.
- R2: Window 0 has base CFG_BASE and a mask of all ones, so it hits exactly the 4 KB page addr[31:12] == CFG_BASE. Its space bit, flags and translation are all zero.
- R3: Writes to window 0 are ignored. Its readback always shows ctrl 0, base {CFG_BASE,12'h000}, mask 32'hFFFFF000 and translation 0.
- R4: Windows with an index of NUM_WIN or above, and indices 6 and 7, read back as zero for every field. Writes to them are ignored and they never hit.
- R5: When several windows hit, the lowest-numbered one wins. hit_idx_o is its 3-bit number.
- R6: If the winning window has ctrl bit 2 set, addr_o[31:12] = (addr[31:12] & ~mask) | (xlat & mask). addr_o[11:0] always equals addr_i[11:0].
- R7: When there is no hit, or the winning window has ctrl bit 2 clear, addr_o equals addr_i.
- R8: On a hit, space_o is bit 0 of the winner's base register (0 = memory), prefetch_o is ctrl bit 1 and rdline_o is ctrl bit 0. With no hit, hit_o, hit_idx_o, space_o, prefetch_o and rdline_o are all 0.
- R9: After reset, every programmable field is zero, so only window 0 can hit.
- R10: The register field codes are 0 = ctrl (bits 2:0), 1 = base (bits 31:12, space type in bit 0), 2 = mask (bits 31:12) and 3 = translation (bits 31:12). A write lands on the next rising edge. Readback is combinational, and unimplemented bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 32 | Address to decode |
| hit_o | output | 1 | Some window matched |
| hit_idx_o | output | 3 | Winning window number |
| space_o | output | 1 | Space type of winner (0 = memory) |
| prefetch_o | output | 1 | Prefetch flag of winner |
| rdline_o | output | 1 | Read-line flag of winner |
| addr_o | output | 32 | Translated or passed-through address |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_win_i | input | 3 | Window selected for write |
| cfg_field_i | input | 2 | Field selected for write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rwin_i | input | 3 | Window selected for readback |
| cfg_rfield_i | input | 2 | Field selected for readback |
| cfg_rdata_o | output | 32 | Readback data |

## Verification
The bench builds the block with NUM_WIN = 4 and CFG_BASE = 20'hF0000. This leaves windows 1 to 3 programmable and windows 4 and 5 absent, so the absent-window rules and the fixed window are both reachable in one build. Random masks of varied prefix length, with bases that overlap, bring priority between several live windows into reach. The translation merge is exercised across many mask widths.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;
  localparam int WIN_MAX = 6;
  localparam int PG_W    = 20;  // bits 31:12

  typedef enum logic [1:0] {
    FLD_CTRL = 2'd0,
    FLD_BASE = 2'd1,
    FLD_MASK = 2'd2,
    FLD_XLAT = 2'd3
  } fld_e;

  localparam int CTRL_RDLINE = 0;
  localparam int CTRL_PREF   = 1;
  localparam int CTRL_XLAT   = 2;
endpackage

// File: rtl/addr_win_slot.sv
module addr_win_slot
  import addr_win_pkg::*;
#(
  parameter bit              PRESENT  = 1'b1,
  parameter bit              FIXED    = 1'b0,
  parameter logic [PG_W-1:0] FIX_BASE = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [1:0]      field_i,
  input  logic [31:0]     wdata_i,
  input  logic [31:0]     addr_i,
  output logic [2:0]      ctrl_o,
  output logic [PG_W-1:0] base_o,
  output logic            space_o,
  output logic [PG_W-1:0] mask_o,
  output logic [PG_W-1:0] xlat_o,
  output logic            hit_o,
  output logic [31:0]     xaddr_o
);
  if (FIXED) begin : g_fix
    logic unused_wr;
    assign unused_wr = ^{clk_i, rst_ni, we_i, field_i, wdata_i};
    assign ctrl_o  = '0;
    assign base_o  = FIX_BASE;
    assign space_o = 1'b0;
    assign mask_o  = '1;
    assign xlat_o  = '0;
  end else if (PRESENT) begin : g_reg
    logic [2:0]      ctrl_q;
    logic [PG_W-1:0] base_q, mask_q, xlat_q;
    logic            space_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_q  <= '0;
        base_q  <= '0;
        space_q <= 1'b0;
        mask_q  <= '0;
        xlat_q  <= '0;
      end else if (we_i) begin
        unique case (fld_e'(field_i))
          FLD_CTRL: ctrl_q <= wdata_i[2:0];
          FLD_BASE: begin
            base_q  <= wdata_i[31:12];
            space_q <= wdata_i[0];
          end
          FLD_MASK: mask_q <= wdata_i[31:12];
          FLD_XLAT: xlat_q <= wdata_i[31:12];
          default: ;
        endcase
      end
    end
    assign ctrl_o  = ctrl_q;
    assign base_o  = base_q;
    assign space_o = space_q;
    assign mask_o  = mask_q;
    assign xlat_o  = xlat_q;
  end else begin : g_none
    logic unused_wr;
    assign unused_wr = ^{clk_i, rst_ni, we_i, field_i, wdata_i};
    assign ctrl_o  = '0;
    assign base_o  = '0;
    assign space_o = 1'b0;
    assign mask_o  = '0;
    assign xlat_o  = '0;
  end

  assign hit_o = (|mask_o) && ((addr_i[31:12] & mask_o) == (base_o & mask_o));

  assign xaddr_o = ctrl_o[CTRL_XLAT]
                 ? {(addr_i[31:12] & ~mask_o) | (xlat_o & mask_o), addr_i[11:0]}
                 : addr_i;
endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
  import addr_win_pkg::*;
#(
  parameter int              NUM_WIN  = 4,
  parameter logic [PG_W-1:0] CFG_BASE = 20'hF0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] addr_i,
  output logic        hit_o,
  output logic [2:0]  hit_idx_o,
  output logic        space_o,
  output logic        prefetch_o,
  output logic        rdline_o,
  output logic [31:0] addr_o,
  input  logic        cfg_we_i,
  input  logic [2:0]  cfg_win_i,
  input  logic [1:0]  cfg_field_i,
  input  logic [31:0] cfg_wdata_i,
  input  logic [2:0]  cfg_rwin_i,
  input  logic [1:0]  cfg_rfield_i,
  output logic [31:0] cfg_rdata_o
);
  localparam int NW = (NUM_WIN < 2) ? 2 : ((NUM_WIN > WIN_MAX) ? WIN_MAX : NUM_WIN);

  logic [2:0]      ctrl_w  [WIN_MAX];
  logic [PG_W-1:0] base_w  [WIN_MAX];
  logic [PG_W-1:0] mask_w  [WIN_MAX];
  logic [PG_W-1:0] xlat_w  [WIN_MAX];
  logic [31:0]     xaddr_w [WIN_MAX];
  logic [WIN_MAX-1:0] space_w, hit_w;

  for (genvar i = 0; i < WIN_MAX; i++) begin : g_win
    addr_win_slot #(
      .PRESENT (i < NW),
      .FIXED   (i == 0),
      .FIX_BASE(CFG_BASE)
    ) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (cfg_we_i && (cfg_win_i == 3'(i))),
      .field_i(cfg_field_i),
      .wdata_i(cfg_wdata_i),
      .addr_i (addr_i),
      .ctrl_o (ctrl_w[i]),
      .base_o (base_w[i]),
      .space_o(space_w[i]),
      .mask_o (mask_w[i]),
      .xlat_o (xlat_w[i]),
      .hit_o  (hit_w[i]),
      .xaddr_o(xaddr_w[i])
    );
  end

  // lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    hit_o      = 1'b0;
    hit_idx_o  = '0;
    space_o    = 1'b0;
    prefetch_o = 1'b0;
    rdline_o   = 1'b0;
    addr_o     = addr_i;
    for (int i = WIN_MAX - 1; i >= 0; i--) begin
      if (hit_w[i]) begin
        hit_o      = 1'b1;
        hit_idx_o  = 3'(i);
        space_o    = space_w[i];
        prefetch_o = ctrl_w[i][CTRL_PREF];
        rdline_o   = ctrl_w[i][CTRL_RDLINE];
        addr_o     = xaddr_w[i];
      end
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    for (int i = 0; i < WIN_MAX; i++) begin
      if (cfg_rwin_i == 3'(i)) begin
        unique case (fld_e'(cfg_rfield_i))
          FLD_CTRL: cfg_rdata_o = {29'd0, ctrl_w[i]};
          FLD_BASE: cfg_rdata_o = {base_w[i], 11'd0, space_w[i]};
          FLD_MASK: cfg_rdata_o = {mask_w[i], 12'd0};
          FLD_XLAT: cfg_rdata_o = {xlat_w[i], 12'd0};
          default:  cfg_rdata_o = '0;
        endcase
      end
    end
  end

  p_cfg_page_hits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[31:12] == CFG_BASE) |-> (hit_o && hit_idx_o == 3'd0 && addr_o == addr_i));

  p_cfg_mask_fixed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rwin_i == 3'd0 && cfg_rfield_i == 2'd2) |-> (cfg_rdata_o == 32'hFFFFF000));

  p_idx_present_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (hit_idx_o < 3'(NW)));

  p_low_bits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o[11:0] == addr_i[11:0]);

  p_miss_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (addr_o == addr_i && !space_o && !prefetch_o && !rdline_o));

  p_single_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($onehot0(hit_w) && hit_o) |-> hit_w[hit_idx_o]);
endmodule

// File: tb/addr_win_decoder_test.sv
module addr_win_decoder_test;
  localparam int          NW   = 4;
  localparam logic [19:0] CFGB = 20'hF0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic        hit, space, pref, rdl;
  logic [2:0]  idx;
  logic [31:0] aout;
  logic        we = 1'b0;
  logic [2:0]  wwin = '0;
  logic [1:0]  wfld = '0;
  logic [31:0] wdat = '0;
  logic [2:0]  rwin = '0;
  logic [1:0]  rfld = '0;
  logic [31:0] rdat;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  addr_win_decoder #(.NUM_WIN(NW), .CFG_BASE(CFGB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .hit_o(hit), .hit_idx_o(idx),
    .space_o(space), .prefetch_o(pref), .rdline_o(rdl), .addr_o(aout),
    .cfg_we_i(we), .cfg_win_i(wwin), .cfg_field_i(wfld), .cfg_wdata_i(wdat),
    .cfg_rwin_i(rwin), .cfg_rfield_i(rfld), .cfg_rdata_o(rdat));

  // model state
  logic [2:0]  m_ctrl [6];
  logic [19:0] m_base [6];
  logic        m_sp   [6];
  logic [19:0] m_mask [6];
  logic [19:0] m_xl   [6];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 6; i++) begin
      m_ctrl[i] = '0; m_base[i] = '0; m_sp[i] = 1'b0; m_mask[i] = '0; m_xl[i] = '0;
    end
    m_base[0] = CFGB;
    m_mask[0] = '1;
  endtask

  task automatic wr(input int w, input int f, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; wwin = 3'(w); wfld = 2'(f); wdat = d;
    @(negedge clk);
    we = 1'b0;
    if (w >= 1 && w < NW) begin
      case (f)
        0: m_ctrl[w] = d[2:0];
        1: begin m_base[w] = d[31:12]; m_sp[w] = d[0]; end
        2: m_mask[w] = d[31:12];
        default: m_xl[w] = d[31:12];
      endcase
    end
  endtask

  function automatic logic [31:0] exp_rd(input int w, input int f);
    if (w >= 6) return '0;
    case (f)
      0: return {29'd0, m_ctrl[w]};
      1: return {m_base[w], 11'd0, m_sp[w]};
      2: return {m_mask[w], 12'd0};
      default: return {m_xl[w], 12'd0};
    endcase
  endfunction

  task automatic rd_chk(input string tag, input int w, input int f);
    @(negedge clk);
    rwin = 3'(w); rfld = 2'(f);
    #2 check(tag, rdat, exp_rd(w, f));
  endtask

  // expected lookup: {hit, idx, space, pref, rdl} and output address
  task automatic lookup_chk(input string tag, input logic [31:0] a);
    logic [6:0]  e_flags;
    logic [31:0] e_addr;
    e_flags = '0;
    e_addr  = a;
    for (int i = 0; i < 6; i++) begin
      if (e_flags[6] == 1'b0 && m_mask[i] != 0 &&
          ((a[31:12] & m_mask[i]) == (m_base[i] & m_mask[i]))) begin
        e_flags = {1'b1, 3'(i), m_sp[i], m_ctrl[i][1], m_ctrl[i][0]};
        if (m_ctrl[i][2])
          e_addr = {(a[31:12] & ~m_mask[i]) | (m_xl[i] & m_mask[i]), a[11:0]};
      end
    end
    @(negedge clk);
    addr = a;
    #2;
    check({tag, " flags"}, {25'd0, hit, idx, space, pref, rdl}, {25'd0, e_flags});
    check({tag, " addr"}, aout, e_addr);
  endtask

  function automatic logic [31:0] rand_mask();
    int k;
    k = $urandom_range(0, 20);
    return {20'hFFFFF << k, 12'd0};
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    rd_chk("R9 ctrl w1", 1, 0);
    rd_chk("R9 base w1", 1, 1);
    rd_chk("R9 mask w3", 3, 2);
    lookup_chk("R9 no hit outside cfg", 32'h1234_5678);
    lookup_chk("R2 cfg page", {CFGB, 12'hABC});
    lookup_chk("R2 next page miss R1", {CFGB + 20'd1, 12'h004});

    // R3 window 0 write ignored
    wr(0, 2, 32'h0);
    wr(0, 1, 32'h1111_1001);
    rd_chk("R3 mask w0", 0, 2);
    rd_chk("R3 base w0", 0, 1);
    rd_chk("R3 ctrl w0", 0, 0);
    rd_chk("R3 xlat w0", 0, 3);
    lookup_chk("R3 cfg still hits", {CFGB, 12'h010});

    // R4 absent windows
    wr(4, 1, 32'h4000_0000);
    wr(4, 2, 32'hF000_0000);
    wr(5, 0, 32'h7);
    wr(7, 2, 32'hFFFF_F000);
    rd_chk("R4 base w4", 4, 1);
    rd_chk("R4 mask w4", 4, 2);
    rd_chk("R4 ctrl w5", 5, 0);
    rd_chk("R4 mask w7", 7, 2);
    rd_chk("R4 base w6", 6, 1);
    lookup_chk("R4 absent never hits", 32'h4123_4567);

    // R10 field codes and readback
    wr(1, 1, 32'h2000_0FFF);
    rd_chk("R10 base drops bits 11:1", 1, 1);
    wr(1, 0, 32'hFFFF_FFFD);
    rd_chk("R10 ctrl 3 bits", 1, 0);

    // R1 zero mask never hits
    lookup_chk("R1 zero mask miss", 32'h2000_0000);

    // R5 overlap: windows 1 and 2 both hit, 1 wins
    wr(1, 2, 32'hF000_0000);
    wr(1, 0, 32'h2);
    wr(2, 1, 32'h2800_0001);
    wr(2, 2, 32'hFF00_0000);
    wr(2, 0, 32'h5);
    wr(2, 3, 32'h9900_0000);
    lookup_chk("R5 lowest wins R8", 32'h2812_3456);
    wr(1, 2, 32'h0);
    lookup_chk("R6 w2 translates R8", 32'h2812_3456);
    // R7 translation disabled
    wr(2, 0, 32'h3);
    lookup_chk("R7 no translation", 32'h28AB_CDEF);
    // R6 partial mask translation
    wr(3, 1, 32'h6000_0000);
    wr(3, 2, 32'hFFFF_0000);
    wr(3, 3, 32'hABCD_E000);
    wr(3, 0, 32'h4);
    lookup_chk("R6 partial mask", 32'h6000_F123);
    rd_chk("R10 xlat w3", 3, 3);

    // random programming and lookups
    for (int round = 0; round < 40; round++) begin
      for (int w = 0; w < 6; w++) begin
        wr(w, 0, $urandom());
        wr(w, 1, $urandom());
        wr(w, 2, ($urandom_range(0, 7) == 0) ? 32'h0 : rand_mask());
        wr(w, 3, $urandom());
      end
      for (int w = 0; w < 8; w++) rd_chk("R10 R4 rand readback", w, $urandom_range(0, 3));
      for (int n = 0; n < 30; n++) begin
        logic [31:0] a;
        int w;
        a = $urandom();
        w = $urandom_range(0, 5);
        if ($urandom_range(0, 1) == 1) a[31:12] = (w == 0) ? CFGB :
          ((m_base[w] & m_mask[w]) | (a[31:12] & ~m_mask[w]));
        lookup_chk("R1 R5 R6 R7 R8 rand", a);
      end
    end

    // R9 reset again clears programming
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    rd_chk("R9 base w2 after reset", 2, 1);
    lookup_chk("R9 only cfg hits", {CFGB, 12'h000});
    lookup_chk("R9 miss after reset", 32'h2800_0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule